// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Aggregator

This block gathers level-sensitive interrupt lines into 32-bit banks. There are up to four banks, so up to 128 lines. It merges them onto a small number of parent interrupt outputs. Each bank has three registers behind a register port with single-cycle access: a writable enable word, a read-only view of the live line levels, and a writable wake word. A line is forwarded only when it is high and enabled. Each parent output then passes only the lines that its own per-bank routing word selects.

The routing words, the enable value loaded at reset and the wake capability are fixed when the block is built. A line that no parent's routing word selects is unused and can never raise a parent. While the system sleeps, a suspend input widens each bank's enable with that bank's wake word. This lets selected used lines wake the system without disturbing the saved enable value. Parent outputs are registered. There is no acknowledge: a parent falls as soon as its contributing lines drop.

Top module: `lvl_irq_aggr`

## Requirements
- R1: The register address is decoded as bank = reg_addr[5:4] and register = reg_addr[3:0]. Register 0x0 is the read/write enable word, 0x4 is the status word and 0x8 is the wake word. A write lands in the addressed register and reads back on the next cycle.
- R2: During synchronous reset each bank's enable word loads its slice of FWD_MASK (bank b at bits 32*b+31..32*b), the wake words clear and all parent outputs are 0.
- R3: The status word of a bank reads as that bank's current src_lvl slice, and writes to it change nothing.
- R4: Reads return 0 and writes have no effect for the following addresses: bank >= NUM_BANKS, reg_addr[7:6] not zero, or register offsets other than 0x0, 0x4 and 0x8.
- R5: Parent p is 1 exactly when some line of some bank is high, effectively enabled and set in parent p's routing word for that bank.
- R6: ROUTE_MASK is packed parent-major. The routing word for parent p and bank b sits at bits 32*(p*NUM_BANKS+b)+31 down to 32*(p*NUM_BANKS+b).
- R7: A line bit that is set in no parent's routing word never raises any parent output, whatever its enable and wake bits are.
- R8: With WAKE_CAPABLE set and suspend high, a bank's effective enable is its enable word ORed with its wake word. With suspend low it is the enable word alone. Suspend never changes the stored enable word.
- R9: A write to a wake word stores only the bits of used lines (lines set in at least one routing word). Bits of unused lines read back as 0.
- R10: Parent outputs are registered. A change on src_lvl, suspend or a stored enable/wake word shows on parent_irq after the next rising clock edge, and not before.
- R11: Lines are level sensitive and need no acknowledge. A parent stays high for as long as a contributing line stays high, and drops one cycle after the last such line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address: bank in [5:4], register in [3:0] |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_lvl | input | NUM_BANKS*32 | Interrupt line levels, bank b at bits 32*b+31..32*b |
| suspend | input | 1 | High while the system is in low-power mode |
| parent_irq | output | NUM_PARENTS | Registered parent interrupt outputs |

## Verification
The readback properties assume that reg_addr is held steady in the cycle after a write. When it is not, they check nothing, so the bench always keeps the address in place until the write has completed. The properties on routing and silence assume that src_lvl and suspend are synchronous to clk. The bench changes every input only on the falling edge. It builds src_lvl from ANDed random words so that any single parent sees a mix of active and idle cycles. The directed steps put unused and unimplemented addresses, unused line bits and suspend transitions at known points.

// File: rtl/lia_pkg.sv
package lia_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int ADDR_W    = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        REG_EN   = 2'd0,
        REG_STAT = 2'd1,
        REG_WAKE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        reg_sel_e          sel;
    } reg_dec_t;

    // Split an address into bank and register; hit only for implemented words.
    function automatic reg_dec_t reg_decode(input logic [ADDR_W-1:0] a, input int nb);
        reg_dec_t d;
        d.bank = a[5:4];
        case (a[3:0])
            4'h0:    d.sel = REG_EN;
            4'h4:    d.sel = REG_STAT;
            4'h8:    d.sel = REG_WAKE;
            default: d.sel = REG_NONE;
        endcase
        d.hit = (a[7:6] == 2'b00) && (int'(d.bank) < nb) && (d.sel != REG_NONE);
        return d;
    endfunction

endpackage

// File: rtl/lia_regs.sv
module lia_regs
    import lia_pkg::*;
#(
    parameter int                      NB       = 4,
    parameter bit                      WAKE_CAP = 1'b1,
    parameter logic [NB*WORD_W-1:0]    FWD      = '0,
    parameter logic [NB*WORD_W-1:0]    USED     = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  word_t                       wdata,
    input  logic [NB-1:0][WORD_W-1:0]   src,
    output word_t                       rdata,
    output logic [NB-1:0][WORD_W-1:0]   en_q,
    output logic [NB-1:0][WORD_W-1:0]   wake_q
);

    reg_dec_t dec;
    assign dec = reg_decode(addr, NB);

    // Enable words: reset to the forward mask, rewritten by software.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                en_q[b] <= FWD[b*WORD_W +: WORD_W];
            end
        end else if (wr && dec.hit && dec.sel == REG_EN) begin
            for (int b = 0; b < NB; b++) begin
                if (dec.bank == BANK_W'(b)) en_q[b] <= wdata;
            end
        end
    end

    // Wake words exist only when the block is built wake-capable.
    if (WAKE_CAP) begin : g_wake
        always_ff @(posedge clk) begin
            if (rst) begin
                wake_q <= '0;
            end else if (wr && dec.hit && dec.sel == REG_WAKE) begin
                for (int b = 0; b < NB; b++) begin
                    if (dec.bank == BANK_W'(b)) wake_q[b] <= wdata & USED[b*WORD_W +: WORD_W];
                end
            end
        end
    end else begin : g_no_wake
        assign wake_q = '0;
    end

    // Combinational read mux; anything not decoded reads zero.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (dec.hit && dec.bank == BANK_W'(b)) begin
                case (dec.sel)
                    REG_EN:   rdata = en_q[b];
                    REG_STAT: rdata = src[b];
                    REG_WAKE: rdata = wake_q[b];
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/lia_route.sv
module lia_route
    import lia_pkg::*;
#(
    parameter int                          NB    = 4,
    parameter int                          NP    = 2,
    parameter logic [NP*NB*WORD_W-1:0]     ROUTE = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NB-1:0][WORD_W-1:0]   src,
    input  logic [NB-1:0][WORD_W-1:0]   eff_en,
    output logic [NP-1:0]               irq_q
);

    logic [NB-1:0][WORD_W-1:0] pend;
    logic [NP-1:0]             hit;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            pend[b] = src[b] & eff_en[b];
        end
    end

    // Parent-major routing words: parent p, bank b at word p*NB+b.
    always_comb begin
        hit = '0;
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < NB; b++) begin
                if (|(pend[b] & ROUTE[(p*NB+b)*WORD_W +: WORD_W])) hit[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= hit;
    end

endmodule

// File: rtl/lvl_irq_aggr.sv
module lvl_irq_aggr
    import lia_pkg::*;
#(
    parameter int  NUM_BANKS    = 4,
    parameter int  NUM_PARENTS  = 2,
    parameter bit  WAKE_CAPABLE = 1'b1,
    parameter logic [NUM_BANKS*WORD_W-1:0] FWD_MASK =
        128'h00000000_80000001_00000000_000000FF,
    parameter logic [NUM_PARENTS*NUM_BANKS*WORD_W-1:0] ROUTE_MASK =
        256'h0000F000_F0000000_0000FFFF_FF000000_00000000_0000000F_FFFF0000_0000FFFF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_wr,
    input  logic [WORD_W-1:0]              reg_wdata,
    output logic [WORD_W-1:0]              reg_rdata,
    input  logic [NUM_BANKS*WORD_W-1:0]    src_lvl,
    input  logic                           suspend,
    output logic [NUM_PARENTS-1:0]         parent_irq
);

    // Union of every parent's routing words: the set of used lines.
    function automatic logic [NUM_BANKS*WORD_W-1:0] used_bits();
        logic [NUM_BANKS*WORD_W-1:0] u;
        u = '0;
        for (int p = 0; p < NUM_PARENTS; p++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                u[b*WORD_W +: WORD_W] = u[b*WORD_W +: WORD_W]
                                      | ROUTE_MASK[(p*NUM_BANKS+b)*WORD_W +: WORD_W];
            end
        end
        return u;
    endfunction

    localparam logic [NUM_BANKS*WORD_W-1:0] USED_MASK = used_bits();

    logic [NUM_BANKS-1:0][WORD_W-1:0] src_w;
    logic [NUM_BANKS-1:0][WORD_W-1:0] en_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0] wake_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0] eff_en;

    assign src_w = src_lvl;

    lia_regs #(
        .NB       (NUM_BANKS),
        .WAKE_CAP (WAKE_CAPABLE),
        .FWD      (FWD_MASK),
        .USED     (USED_MASK)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .src    (src_w),
        .rdata  (reg_rdata),
        .en_q   (en_q),
        .wake_q (wake_q)
    );

    // Suspend widens the enable with the wake word; the saved enable is untouched.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            eff_en[b] = suspend ? (en_q[b] | wake_q[b]) : en_q[b];
        end
    end

    lia_route #(
        .NB    (NUM_BANKS),
        .NP    (NUM_PARENTS),
        .ROUTE (ROUTE_MASK)
    ) u_route (
        .clk    (clk),
        .rst    (rst),
        .src    (src_w),
        .eff_en (eff_en),
        .irq_q  (parent_irq)
    );

endmodule

// File: rtl/lia_chk.sv
module lia_chk
    import lia_pkg::*;
#(
    parameter int                          NB       = 4,
    parameter int                          NP       = 2,
    parameter bit                          WAKE_CAP = 1'b1,
    parameter logic [NP*NB*WORD_W-1:0]     ROUTE    = '0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic                     reg_wr,
    input logic [WORD_W-1:0]        reg_wdata,
    input logic [WORD_W-1:0]        reg_rdata,
    input logic [NB*WORD_W-1:0]     src_lvl,
    input logic [NP-1:0]            parent_irq
);

    function automatic logic [NB*WORD_W-1:0] chk_used();
        logic [NB*WORD_W-1:0] u;
        u = '0;
        for (int i = 0; i < NP*NB; i++) begin
            u[(i%NB)*WORD_W +: WORD_W] = u[(i%NB)*WORD_W +: WORD_W] | ROUTE[i*WORD_W +: WORD_W];
        end
        return u;
    endfunction

    localparam logic [NB*WORD_W-1:0] USED_C = chk_used();

    reg_dec_t dec;
    word_t    src_word;
    word_t    used_word;

    assign dec = reg_decode(reg_addr, NB);

    always_comb begin
        src_word  = '0;
        used_word = '0;
        for (int b = 0; b < NB; b++) begin
            if (dec.bank == BANK_W'(b)) begin
                src_word  = src_lvl[b*WORD_W +: WORD_W];
                used_word = USED_C[b*WORD_W +: WORD_W];
            end
        end
    end

    // R4: undecoded addresses read zero
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |-> reg_rdata == '0);

    // R3: status word mirrors the live lines of the bank
    p_status_view_r3: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && dec.sel == REG_STAT) |-> reg_rdata == src_word);

    // R1: enable write reads back next cycle at the same address
    p_enable_readback_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dec.hit && dec.sel == REG_EN)
        |=> (!$stable(reg_addr) || reg_rdata == $past(reg_wdata)));

    // R9: wake write keeps only used-line bits
    p_wake_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dec.hit && dec.sel == REG_WAKE)
        |=> (!$stable(reg_addr)
             || reg_rdata == (WAKE_CAP ? ($past(reg_wdata) & used_word) : '0)));

    // R7: with only unused lines high, no parent rises
    p_unused_silent_r7: assert property (@(posedge clk) disable iff (rst)
        ((src_lvl & USED_C) == '0) |=> parent_irq == '0);

endmodule

bind lvl_irq_aggr lia_chk #(
    .NB       (NUM_BANKS),
    .NP       (NUM_PARENTS),
    .WAKE_CAP (WAKE_CAPABLE),
    .ROUTE    (ROUTE_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .src_lvl    (src_lvl),
    .parent_irq (parent_irq)
);

// File: tb/sim_lvl_irq_aggr.sv
`timescale 1ns/1ps
module sim_lvl_irq_aggr;

    localparam int NB = 3;
    localparam int NP = 2;
    localparam logic [95:0]  T_FWD   = 96'h80000001_00000000_000000FF;
    localparam logic [191:0] T_ROUTE =
        192'hF0000000_0000FFFF_FF000000_0000000F_FFFF0000_0000FFFF;
    localparam logic [95:0]  T_USED  = 96'hF000000F_FFFFFFFF_FF00FFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    addr;
    logic          wr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [95:0]   src;
    logic          susp;
    logic [1:0]    irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] en_m   [NB];
    logic [31:0] wake_m [NB];

    always #4 clk = ~clk;

    lvl_irq_aggr #(
        .NUM_BANKS    (NB),
        .NUM_PARENTS  (NP),
        .WAKE_CAPABLE (1'b1),
        .FWD_MASK     (T_FWD),
        .ROUTE_MASK   (T_ROUTE)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (addr),
        .reg_wr     (wr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .src_lvl    (src),
        .suspend    (susp),
        .parent_irq (irq)
    );

    function automatic logic [1:0] exp_irq();
        logic [1:0] r;
        r = '0;
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < NB; b++) begin
                logic [31:0] e;
                e = susp ? (en_m[b] | wake_m[b]) : en_m[b];
                if (|(src[b*32 +: 32] & e & T_ROUTE[(p*NB+b)*32 +: 32])) r[p] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_en(input int b, input logic [31:0] v);
        wr_reg(8'(b*16), v);
        en_m[b] = v;
    endtask

    task automatic set_wake(input int b, input logic [31:0] v);
        wr_reg(8'(b*16 + 8), v);
        wake_m[b] = v & T_USED[b*32 +: 32];
    endtask

    // Drive src/suspend at a falling edge, check parent outputs one edge later.
    task automatic drive_chk(input string req, input logic [95:0] s, input logic sp);
        @(negedge clk);
        src = s; susp = sp;
        @(negedge clk);
        chk(req, 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; addr = '0; wr = 1'b0; wdata = '0; src = '0; susp = 1'b0;
        for (int b = 0; b < NB; b++) begin
            en_m[b]   = T_FWD[b*32 +: 32];
            wake_m[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        chk("R2 irq after reset", 32'(irq), 32'h0);
        rd_chk("R2 enable bank0 reset", 8'h00, 32'h000000FF);
        rd_chk("R2 enable bank1 reset", 8'h10, 32'h00000000);
        rd_chk("R2 enable bank2 reset", 8'h20, 32'h80000001);
        rd_chk("R2 wake bank0 reset",   8'h08, 32'h0);

        // R1: enable write and readback
        set_en(1, 32'h12345678);
        rd_chk("R1 enable bank1 readback", 8'h10, 32'h12345678);

        // R3: status view and write ignored
        @(negedge clk);
        src = {32'h0, 32'hA5A50000, 32'h00000000};
        rd_chk("R3 status bank1", 8'h14, 32'hA5A50000);
        wr_reg(8'h04, 32'hFFFFFFFF);
        rd_chk("R3 status write leaves enable", 8'h00, en_m[0]);
        rd_chk("R3 status write leaves status", 8'h04, 32'h0);

        // R4: unimplemented addresses
        rd_chk("R4 bank3 enable",  8'h30, 32'h0);
        rd_chk("R4 offset 0xC",    8'h0C, 32'h0);
        rd_chk("R4 high addr",     8'h40, 32'h0);
        rd_chk("R4 offset 0x2",    8'h02, 32'h0);
        wr_reg(8'h30, 32'hDEADBEEF);
        wr_reg(8'h40, 32'hDEADBEEF);
        wr_reg(8'h0C, 32'hDEADBEEF);
        wr_reg(8'h48, 32'hDEADBEEF);
        rd_chk("R4 enable0 untouched", 8'h00, en_m[0]);
        rd_chk("R4 enable1 untouched", 8'h10, en_m[1]);
        rd_chk("R4 enable2 untouched", 8'h20, en_m[2]);
        rd_chk("R4 wake0 untouched",   8'h08, 32'h0);

        // R5 / R6: directed routing
        set_en(0, 32'hFFFFFFFF); set_en(1, 32'h0); set_en(2, 32'h0);
        drive_chk("R5 b0 bit0 to parent0", {64'h0, 32'h00000001}, 1'b0);
        chk("R5 b0 bit0 value", 32'(irq), 32'h1);
        drive_chk("R5 b0 bit24 to parent1", {64'h0, 32'h01000000}, 1'b0);
        chk("R5 b0 bit24 value", 32'(irq), 32'h2);
        drive_chk("R5 disabled bank1", {32'h0, 32'h00000001, 32'h0}, 1'b0);
        chk("R5 disabled value", 32'(irq), 32'h0);
        set_en(1, 32'hFFFFFFFF);
        drive_chk("R6 b1 bit0 to parent1", {32'h0, 32'h00000001, 32'h0}, 1'b0);
        chk("R6 b1 bit0 value", 32'(irq), 32'h2);
        drive_chk("R6 b1 bit16 to parent0", {32'h0, 32'h00010000, 32'h0}, 1'b0);
        chk("R6 b1 bit16 value", 32'(irq), 32'h1);
        set_en(2, 32'hFFFFFFFF);
        drive_chk("R6 b2 bit31 to parent1", {32'h80000000, 64'h0}, 1'b0);
        chk("R6 b2 bit31 value", 32'(irq), 32'h2);

        // R7: unused lines stay silent, even with wake set during suspend
        set_wake(0, 32'hFFFFFFFF);
        drive_chk("R7 unused lines", {32'h0FFFFFF0, 32'h0, 32'h00FF0000}, 1'b0);
        chk("R7 unused value", 32'(irq), 32'h0);
        drive_chk("R7 unused in suspend", {32'h0FFFFFF0, 32'h0, 32'h00FF0000}, 1'b1);
        chk("R7 unused suspend value", 32'(irq), 32'h0);

        // R10: one-cycle latency
        drive_chk("R10 idle", 96'h0, 1'b0);
        @(negedge clk);
        src = {64'h0, 32'h00000002};
        #1;
        chk("R10 before edge", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R10 after edge", 32'(irq), 32'h1);

        // R11: level hold and release without acknowledge
        repeat (4) begin
            @(negedge clk);
            chk("R11 held while line high", 32'(irq), 32'h1);
        end
        drive_chk("R11 release", 96'h0, 1'b0);
        chk("R11 release value", 32'(irq), 32'h0);

        // R8 / R9: wake override during suspend
        set_en(0, 32'h0);
        set_wake(0, 32'hFFFFFFFF);
        rd_chk("R9 wake masked to used", 8'h08, 32'hFF00FFFF);
        set_wake(2, 32'hFFFFFFFF);
        rd_chk("R9 wake bank2 masked", 8'h28, 32'hF000000F);
        drive_chk("R8 awake, enable off", {64'h0, 32'h00000008}, 1'b0);
        chk("R8 awake value", 32'(irq), 32'h0);
        drive_chk("R8 suspend wakes", {64'h0, 32'h00000008}, 1'b1);
        chk("R8 suspend value", 32'(irq), 32'h1);
        rd_chk("R8 saved enable kept", 8'h00, 32'h0);
        drive_chk("R8 suspend falls", {64'h0, 32'h00000008}, 1'b0);
        chk("R8 suspend fall value", 32'(irq), 32'h0);

        // Random mix, R5 against the bench model
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            int unsigned b;
            op = $urandom_range(0, 3);
            b  = $urandom_range(0, NB - 1);
            if (op == 0)      set_en(int'(b), $urandom() | $urandom());
            else if (op == 1) set_wake(int'(b), $urandom());
            drive_chk("R5 random",
                      {$urandom() & $urandom() & $urandom(),
                       $urandom() & $urandom() & $urandom(),
                       $urandom() & $urandom() & $urandom()},
                      1'($urandom_range(0, 1)));
            if (i % 16 == 0) begin
                rd_chk("R3 random status", 8'(b*16 + 4), src[b*32 +: 32]);
                rd_chk("R9 random wake",   8'(b*16 + 8), wake_m[b]);
                rd_chk("R1 random enable", 8'(b*16),     en_m[b]);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule